// File: doc/BRIEF.md
# Pointer Bounds Metadata Cache and Checker

This block sits beside a processor's general-purpose register file and guards every load and store against spatial memory-safety violations. For each architectural register it keeps a small entry that describes the allocation the register points into: the lowest legal byte address (base), the first address past the end (bound, equal to base plus the allocation size), the pointer identifier and a valid flag. The entry for a register is chosen directly by that register's number.

Metadata is not kept per register in memory. It lives in one shared pointer-limits region. The pipeline asks the block to fetch the record for a pointer identifier into a chosen register's entry. The block forms the record address from a dedicated limits-base register plus the identifier and issues one request on a simple request/response port. It stays busy until the response arrives, and the pipeline must stall uses of that register meanwhile. The limits-base register is written and read through a special-register port with an immediate selector. Each memory access is compared combinationally against the entry of its base register in the same cycle. A failing access is suppressed at once and reported by a one-cycle fault pulse in the following cycle.

Every memory word carries one extra tag bit: 0 for data or an instruction, 1 for a pointer. When the pipeline writes a register with a value whose tag is 0, the entry is dropped. A register that holds no pointer is not checked.

Top module: `ptr_bounds_guard`

## Requirements
- R1: After reset every table entry is invalid, so no access is blocked. The limits-base register reads as zero, and `fill_busy`, `mem_req` and `fault` are low.
- R2: A special-register write with `sr_sel` equal to parameter `LIM_SEL` (default 12'h7C1) loads the limits-base register, and a write with any other selector changes nothing. `sr_rdata` shows the limits-base register while `sr_rd_sel` equals `LIM_SEL`, and zero otherwise.
- R3: A metadata fetch accepted while idle raises `mem_req` for exactly one cycle, in the cycle after acceptance. `mem_req_addr` equals the limits-base value at acceptance plus the zero-extended `fill_id`.
- R4: `fill_busy` is high from the cycle after acceptance until the edge at which a response is taken. `fill_busy_idx` names the destination register throughout. A response is taken only in a cycle after the one in which `mem_req` is high.
- R5: A taken response writes `mem_rsp_base`, `mem_rsp_bound` and the request's pointer id into the destination entry and marks the entry valid.
- R6: For a valid entry, an access is legal only when base <= `acc_addr` and `acc_addr` + `acc_size` <= bound. The sum is formed one bit wider than an address, so it cannot wrap. `acc_allow` follows in the same cycle and is low for an illegal access and whenever `acc_valid` is low.
- R7: An access through a register whose entry is invalid is always allowed and raises no fault.
- R8: A register write with `rf_wr_tag` = 0 invalidates that register's entry. A write with `rf_wr_tag` = 1 leaves the entry unchanged.
- R9: An illegal access raises `fault` for one cycle in the next cycle, carrying the register index, the access address and the entry's pointer id.
- R10: A fetch request made while a fetch is outstanding is ignored. It changes neither the destination nor the request, and it writes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sr_wr_en | input | 1 | Special-register write strobe |
| sr_sel | input | SEL_W | Selector for the write |
| sr_wdata | input | ADDR_W | Write data |
| sr_rd_sel | input | SEL_W | Selector for the read |
| sr_rdata | output | ADDR_W | Read data, zero for unknown selectors |
| rf_wr_en | input | 1 | Register-file write strobe |
| rf_wr_idx | input | IDX_W | Register written |
| rf_wr_tag | input | 1 | Tag of the written value: 1 pointer, 0 data |
| fill_req | input | 1 | Request to fetch metadata |
| fill_dst | input | IDX_W | Destination register entry |
| fill_id | input | ID_W | Pointer identifier to fetch |
| fill_busy | output | 1 | A fetch is outstanding |
| fill_busy_idx | output | IDX_W | Destination of the outstanding fetch |
| mem_req | output | 1 | Request to pointer-limits memory, one cycle |
| mem_req_addr | output | ADDR_W | Address of the metadata record |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_base | input | ADDR_W | Returned base |
| mem_rsp_bound | input | ADDR_W | Returned bound |
| acc_valid | input | 1 | Memory access presented |
| acc_reg | input | IDX_W | Base register of the access |
| acc_addr | input | ADDR_W | Effective address |
| acc_size | input | SZ_W | Access size in bytes |
| acc_allow | output | 1 | Access may proceed |
| fault | output | 1 | Bounds fault pulse |
| fault_idx | output | IDX_W | Register of the faulting access |
| fault_addr | output | ADDR_W | Address of the faulting access |
| fault_id | output | ID_W | Pointer id of the faulting entry |

## Verification
The check is tried with accesses placed exactly on the lower and upper edges of an allocation and one byte outside each edge. These cases separate an inclusive comparison from an exclusive one and show whether the access size is added before comparing with the bound. A record near the top of the address space shows whether the end-address sum wraps. The same out-of-range address is presented through a filled register, a register cleared by a data write, a register rewritten with a pointer tag and a register never filled. This shows that validity, and not the address alone, decides the outcome. Back-to-back fetch requests and selector mismatches on the special-register port show that only the intended request or selector takes effect.

// File: rtl/pbg_pkg.sv
// Shared types for the pointer bounds guard.
package pbg_pkg;
    // States of the metadata fetch sequencer.
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fill_state_e;
endpackage

// File: rtl/pbg_table.sv
// Per-register metadata table.
// Holds base, bound, pointer id and valid for each architectural register.
// Assumes: an update and a clear of the same entry in one cycle resolve to
// the clear (the newer register write wins). Read is combinational.
module pbg_table #(
    parameter int NREG   = 32,
    parameter int IDX_W  = 5,
    parameter int ADDR_W = 32,
    parameter int ID_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [ADDR_W-1:0] upd_base,
    input  logic [ADDR_W-1:0] upd_bound,
    input  logic [ID_W-1:0]   upd_id,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_bound,
    output logic [ID_W-1:0]   rd_id
);
    logic              vld_q   [NREG];
    logic [ADDR_W-1:0] base_q  [NREG];
    logic [ADDR_W-1:0] bound_q [NREG];
    logic [ID_W-1:0]   id_q    [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        // Entry storage: fill response sets it, a data write clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i]   <= 1'b0;
                base_q[i]  <= '0;
                bound_q[i] <= '0;
                id_q[i]    <= '0;
            end else begin
                if (upd_en && upd_idx == IDX_W'(i)) begin
                    vld_q[i]   <= 1'b1;
                    base_q[i]  <= upd_base;
                    bound_q[i] <= upd_bound;
                    id_q[i]    <= upd_id;
                end
                if (clr_en && clr_idx == IDX_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    // Direct one-level lookup by register number.
    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_base  = base_q[rd_idx];
        rd_bound = bound_q[rd_idx];
        rd_id    = id_q[rd_idx];
    end
endmodule

// File: rtl/pbg_fill.sv
// Metadata fetch sequencer.
// Accepts one fetch at a time, issues one memory request and waits for
// the response. Assumes the memory answers no earlier than the cycle after
// the request. Requests arriving while busy are dropped.
module pbg_fill
    import pbg_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int ADDR_W = 32,
    parameter int ID_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [IDX_W-1:0]  dst,
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] lim_base,
    input  logic              rsp_valid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic [IDX_W-1:0]  busy_idx,
    output logic [ID_W-1:0]   busy_id,
    output logic              done
);
    fill_state_e       state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;

    // Sequencer state and captured request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            idx_q   <= '0;
            id_q    <= '0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                FS_IDLE: if (req) begin
                    state_q <= FS_REQ;
                    idx_q   <= dst;
                    id_q    <= id;
                    addr_q  <= lim_base + ADDR_W'(id);
                end
                FS_REQ:  state_q <= FS_WAIT;
                FS_WAIT: if (rsp_valid) state_q <= FS_IDLE;
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_req  = (state_q == FS_REQ);
        mem_addr = addr_q;
        busy     = (state_q != FS_IDLE);
        busy_idx = idx_q;
        busy_id  = id_q;
        done     = (state_q == FS_WAIT) && rsp_valid;
    end
endmodule

// File: rtl/pbg_check.sv
// Combinational bounds comparator.
// Flags an access whose byte range leaves [base, bound). The end address
// is summed one bit wider so it cannot wrap. Invalid entries never flag.
module pbg_check #(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 4
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size,
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] bound,
    output logic              viol
);
    localparam int EW = ADDR_W + 1;
    logic [EW-1:0] end_sum;
    logic          lo_ok;
    logic          hi_ok;

    // Two compares in parallel, one add ahead of the upper one.
    always_comb begin
        end_sum = {1'b0, addr} + EW'(size);
        lo_ok   = (addr >= base);
        hi_ok   = (end_sum <= {1'b0, bound});
        viol    = acc_valid && ent_valid && !(lo_ok && hi_ok);
    end
endmodule

// File: rtl/ptr_bounds_guard.sv
// Pointer bounds metadata cache and checker (top).
// Holds the limits-base special register, the per-register table, the
// fetch sequencer and the same-cycle access check, and registers the
// fault report. Assumes the pipeline stalls uses of fill_busy_idx.
module ptr_bounds_guard #(
    parameter int          NREG    = 32,
    parameter int          ADDR_W  = 32,
    parameter int          ID_W    = 12,
    parameter int          SZ_W    = 4,
    parameter int          SEL_W   = 12,
    parameter logic [11:0] LIM_SEL = 12'h7C1,
    localparam int         IDX_W   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_wr_en,
    input  logic [SEL_W-1:0]  sr_sel,
    input  logic [ADDR_W-1:0] sr_wdata,
    input  logic [SEL_W-1:0]  sr_rd_sel,
    output logic [ADDR_W-1:0] sr_rdata,
    input  logic              rf_wr_en,
    input  logic [IDX_W-1:0]  rf_wr_idx,
    input  logic              rf_wr_tag,
    input  logic              fill_req,
    input  logic [IDX_W-1:0]  fill_dst,
    input  logic [ID_W-1:0]   fill_id,
    output logic              fill_busy,
    output logic [IDX_W-1:0]  fill_busy_idx,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_base,
    input  logic [ADDR_W-1:0] mem_rsp_bound,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_reg,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SZ_W-1:0]   acc_size,
    output logic              acc_allow,
    output logic              fault,
    output logic [IDX_W-1:0]  fault_idx,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ID_W-1:0]   fault_id
);
    logic [ADDR_W-1:0] lim_base_q;
    logic              done;
    logic [ID_W-1:0]   busy_id;
    logic              ent_valid;
    logic [ADDR_W-1:0] ent_base;
    logic [ADDR_W-1:0] ent_bound;
    logic [ID_W-1:0]   ent_id;
    logic              viol;
    logic              fault_q;
    logic [IDX_W-1:0]  fault_idx_q;
    logic [ADDR_W-1:0] fault_addr_q;
    logic [ID_W-1:0]   fault_id_q;

    // Limits-base special register, written by selector match.
    always_ff @(posedge clk) begin
        if (!rst_n) lim_base_q <= '0;
        else if (sr_wr_en && sr_sel == SEL_W'(LIM_SEL)) lim_base_q <= sr_wdata;
    end

    // Special-register read mux.
    assign sr_rdata = (sr_rd_sel == SEL_W'(LIM_SEL)) ? lim_base_q : '0;

    pbg_fill #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (fill_req),
        .dst       (fill_dst),
        .id        (fill_id),
        .lim_base  (lim_base_q),
        .rsp_valid (mem_rsp_valid),
        .mem_req   (mem_req),
        .mem_addr  (mem_req_addr),
        .busy      (fill_busy),
        .busy_idx  (fill_busy_idx),
        .busy_id   (busy_id),
        .done      (done)
    );

    pbg_table #(.NREG(NREG), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (done),
        .upd_idx   (fill_busy_idx),
        .upd_base  (mem_rsp_base),
        .upd_bound (mem_rsp_bound),
        .upd_id    (busy_id),
        .clr_en    (rf_wr_en && !rf_wr_tag),
        .clr_idx   (rf_wr_idx),
        .rd_idx    (acc_reg),
        .rd_valid  (ent_valid),
        .rd_base   (ent_base),
        .rd_bound  (ent_bound),
        .rd_id     (ent_id)
    );

    pbg_check #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_check (
        .acc_valid (acc_valid),
        .addr      (acc_addr),
        .size      (acc_size),
        .ent_valid (ent_valid),
        .base      (ent_base),
        .bound     (ent_bound),
        .viol      (viol)
    );

    // Suppress the access in the cycle it fails.
    assign acc_allow = acc_valid && !viol;

    // Fault report: one pulse per failing access, in the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q      <= 1'b0;
            fault_idx_q  <= '0;
            fault_addr_q <= '0;
            fault_id_q   <= '0;
        end else begin
            fault_q <= viol;
            if (viol) begin
                fault_idx_q  <= acc_reg;
                fault_addr_q <= acc_addr;
                fault_id_q   <= ent_id;
            end
        end
    end

    assign fault      = fault_q;
    assign fault_idx  = fault_idx_q;
    assign fault_addr = fault_addr_q;
    assign fault_id   = fault_id_q;
endmodule

// File: rtl/pbg_checker.sv
// Protocol checker for ptr_bounds_guard, attached by bind.
module pbg_checker #(
    parameter int          ADDR_W  = 32,
    parameter int          SEL_W   = 12,
    parameter int          IDX_W   = 5,
    parameter logic [11:0] LIM_SEL = 12'h7C1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sr_wr_en,
    input logic [SEL_W-1:0]  sr_sel,
    input logic [ADDR_W-1:0] sr_wdata,
    input logic [SEL_W-1:0]  sr_rd_sel,
    input logic [ADDR_W-1:0] sr_rdata,
    input logic              fill_req,
    input logic              fill_busy,
    input logic [IDX_W-1:0]  fill_busy_idx,
    input logic              mem_req,
    input logic              mem_rsp_valid,
    input logic              acc_valid,
    input logic              acc_allow,
    input logic              fault
);
    AST_SR_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sr_wr_en) && $past(sr_sel) == SEL_W'(LIM_SEL) && sr_rd_sel == SEL_W'(LIM_SEL))
        |-> sr_rdata == $past(sr_wdata)); // R2
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fill_busy); // R4
    AST_ALLOW_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_allow |-> acc_valid); // R6
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(acc_valid && !acc_allow)); // R9
    AST_BUSY_HOLDS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && fill_req && !mem_rsp_valid) |=> (fill_busy && $stable(fill_busy_idx))); // R10
endmodule

bind ptr_bounds_guard pbg_checker #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .LIM_SEL(LIM_SEL)
) u_pbg_checker (.*);

// File: tb/tb_ptr_bounds_guard.sv
`timescale 1ns/1ps
module tb_ptr_bounds_guard;
    localparam int NREG = 32, ADDR_W = 32, ID_W = 12, SZ_W = 4, SEL_W = 12;
    localparam int IDX_W = 5;
    localparam logic [11:0] SEL = 12'h7C1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sr_wr_en = 0; logic [SEL_W-1:0] sr_sel = 0; logic [ADDR_W-1:0] sr_wdata = 0;
    logic [SEL_W-1:0] sr_rd_sel = 0; logic [ADDR_W-1:0] sr_rdata;
    logic rf_wr_en = 0; logic [IDX_W-1:0] rf_wr_idx = 0; logic rf_wr_tag = 0;
    logic fill_req = 0; logic [IDX_W-1:0] fill_dst = 0; logic [ID_W-1:0] fill_id = 0;
    logic fill_busy; logic [IDX_W-1:0] fill_busy_idx;
    logic mem_req; logic [ADDR_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 0; logic [ADDR_W-1:0] mem_rsp_base = 0, mem_rsp_bound = 0;
    logic acc_valid = 0; logic [IDX_W-1:0] acc_reg = 0; logic [ADDR_W-1:0] acc_addr = 0;
    logic [SZ_W-1:0] acc_size = 0; logic acc_allow;
    logic fault; logic [IDX_W-1:0] fault_idx; logic [ADDR_W-1:0] fault_addr; logic [ID_W-1:0] fault_id;

    int checks = 0, errors = 0;
    logic [ADDR_W-1:0] lim_model = '0;

    always #2.5 clk = ~clk;

    ptr_bounds_guard #(.NREG(NREG), .ADDR_W(ADDR_W), .ID_W(ID_W), .SZ_W(SZ_W),
                       .SEL_W(SEL_W), .LIM_SEL(SEL)) dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1: reset state at the ports.
    task automatic t_reset();
        @(negedge clk);
        sr_rd_sel = SEL; acc_valid = 1; acc_reg = 3; acc_addr = 32'hFFFF_FFF0; acc_size = 8;
        #0.5;
        chk("R1 lim base zero", sr_rdata, 0);
        chk("R1 busy low", fill_busy, 0);
        chk("R1 mem_req low", mem_req, 0);
        chk("R1 invalid entry allows", acc_allow, 1);
        @(negedge clk); acc_valid = 0; #0.5;
        chk("R1 no fault", fault, 0);
    endtask

    // R2: selector-qualified write and read of the limits base.
    task automatic t_sreg();
        @(negedge clk); sr_wr_en = 1; sr_sel = SEL + 1; sr_wdata = 32'hDEAD_0000;
        @(negedge clk); sr_wr_en = 0; sr_rd_sel = SEL; #0.5;
        chk("R2 other selector ignored", sr_rdata, lim_model);
        @(negedge clk); sr_wr_en = 1; sr_sel = SEL; sr_wdata = 32'h0001_0000;
        @(negedge clk); sr_wr_en = 0; lim_model = 32'h0001_0000; #0.5;
        chk("R2 write then read", sr_rdata, lim_model);
        sr_rd_sel = SEL - 1; #0.5;
        chk("R2 other read selector zero", sr_rdata, 0);
        sr_rd_sel = SEL;
    endtask

    // R3/R4/R5: full fetch sequence with response one cycle after the request.
    task automatic t_fill(input int dst, input int id, input logic [31:0] b, input logic [31:0] bd);
        @(negedge clk); fill_req = 1; fill_dst = IDX_W'(dst); fill_id = ID_W'(id);
        @(negedge clk); fill_req = 0; #0.5;
        chk("R3 request pulse", mem_req, 1);
        chk("R3 request address", mem_req_addr, lim_model + 32'(id));
        chk("R4 busy during request", fill_busy, 1);
        chk("R4 busy index", fill_busy_idx, 64'(dst));
        @(negedge clk); #0.5;
        chk("R3 request single cycle", mem_req, 0);
        chk("R4 busy while waiting", fill_busy, 1);
        mem_rsp_valid = 1; mem_rsp_base = b; mem_rsp_bound = bd;
        @(negedge clk); mem_rsp_valid = 0; #0.5;
        chk("R4 busy cleared after response", fill_busy, 0);
    endtask

    // R6/R7/R9: one access, allow checked now, fault checked next cycle.
    task automatic t_access(input string req, input int r, input logic [31:0] a, input int sz,
                            input bit exp_ok, input int exp_id);
        @(negedge clk); acc_valid = 1; acc_reg = IDX_W'(r); acc_addr = a; acc_size = SZ_W'(sz); #0.5;
        chk({req, " allow"}, acc_allow, 64'(exp_ok));
        @(negedge clk); acc_valid = 0; #0.5;
        chk({req, " R9 fault"}, fault, 64'(!exp_ok));
        if (!exp_ok) begin
            chk("R9 fault index", fault_idx, 64'(r));
            chk("R9 fault address", fault_addr, a);
            chk("R9 fault id", fault_id, 64'(exp_id));
        end
        @(negedge clk); #0.5;
        chk("R9 fault one cycle", fault, 0);
    endtask

    // R5/R6: boundary cases on a filled entry.
    task automatic t_bounds();
        t_fill(4, 7, 32'h0000_1000, 32'h0000_1014);
        t_access("R5 R6 at base", 4, 32'h1000, 4, 1, 7);
        t_access("R6 end equals bound", 4, 32'h1010, 4, 1, 7);
        t_access("R6 below base", 4, 32'h0FFF, 1, 0, 7);
        t_access("R6 one past bound", 4, 32'h1011, 4, 0, 7);
        t_fill(9, 3, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
        t_access("R6 no wrap near top", 9, 32'hFFFF_FFFC, 8, 0, 3);
        t_access("R6 last byte at top", 9, 32'hFFFF_FFFE, 1, 1, 3);
        @(negedge clk); acc_valid = 0; acc_reg = 4; acc_addr = 32'h0; #0.5;
        chk("R6 no access no allow", acc_allow, 0);
    endtask

    // R7/R8: tag-0 write drops the entry; tag-1 write keeps it.
    task automatic t_tags();
        t_access("R7 never filled", 20, 32'h0, 8, 1, 0);
        @(negedge clk); rf_wr_en = 1; rf_wr_idx = 4; rf_wr_tag = 1;
        @(negedge clk); rf_wr_en = 0;
        t_access("R8 pointer tag keeps entry", 4, 32'h2000, 4, 0, 7);
        @(negedge clk); rf_wr_en = 1; rf_wr_idx = 4; rf_wr_tag = 0;
        @(negedge clk); rf_wr_en = 0;
        t_access("R8 R7 data tag clears entry", 4, 32'h2000, 4, 1, 0);
    endtask

    // R10: a second request while busy is dropped.
    task automatic t_busy_ignore();
        @(negedge clk); fill_req = 1; fill_dst = 12; fill_id = 5;
        @(negedge clk); fill_dst = 13; fill_id = 9; #0.5;
        chk("R10 first request issued", mem_req, 1);
        @(negedge clk); fill_req = 0; #0.5;
        chk("R10 no second request", mem_req, 0);
        chk("R10 destination kept", fill_busy_idx, 12);
        chk("R10 address kept", mem_req_addr, lim_model + 32'd5);
        mem_rsp_valid = 1; mem_rsp_base = 32'h3000; mem_rsp_bound = 32'h3010;
        @(negedge clk); mem_rsp_valid = 0; #0.5;
        chk("R10 idle after single response", fill_busy, 0);
        chk("R10 no extra request", mem_req, 0);
        t_access("R10 dropped dst not filled", 13, 32'h5000, 4, 1, 0);
        t_access("R10 first dst filled", 12, 32'h5000, 4, 0, 5);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_sreg();
        t_bounds();
        t_tags();
        t_busy_ignore();
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule